// File: doc/BRIEF.md
# Five-Point Piecewise Calibration Corrector

This block takes one raw 16-bit converter reading in unsigned offset-binary form, together with five calibration readings taken earlier at known input levels (the most negative level, half of it, zero, half of the most positive level, and the most positive level). It finds the segment between two adjacent calibration readings that holds the raw value, then maps that segment linearly onto a fixed output band. Each segment has its own scale constant and base code. A shared restoring divider does the division, one quotient bit per clock. Calibration storage and table selection belong to the surrounding logic, which presents the five readings alongside each raw value.

A request is offered with `in_valid`. It is taken in the cycle when `in_ready` is high. The corrected code appears on `out_code` while `out_valid` is high, and that pulse lasts one cycle. A bypass flag passes the raw code straight through with no correction. A segment whose upper reading is not above its lower reading is treated as zero-width and yields the segment's base code without dividing.

The controller has three states. ST_IDLE waits for a request. From there, a bypass or zero-width request goes straight to ST_DONE, and any other request starts the divider and goes to ST_DIVIDE. ST_DIVIDE holds until the divider flags completion, then moves to ST_DONE and registers the result. ST_DONE presents the result for one cycle and returns to ST_IDLE.

Top module: `cal_corrector`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: When raw >= pos_half, the output is (raw − pos_half)·0x3FF8 / (pos_full − pos_half) + 0xBFF8, with the quotient truncated.
- R3: When zero <= raw < pos_half, the output is (raw − zero)·0x3FF8 / (pos_half − zero) + 0x8000.
- R4: When neg_half <= raw < zero, the output is 0x8000 − (zero − raw)·0x3FF9 / (zero − neg_half).
- R5: When raw < neg_half, the output is 0x4007 − (neg_half − raw)·0x3FF9 / (neg_half − neg_full).
- R6: With `in_bypass` = 1, `out_code` equals the raw code, and `out_valid` rises in the cycle right after the accepting edge.
- R7: Results are clamped: any value above 0xFFFF gives 0xFFFF and any value below 0 gives 0x0000.
- R8: If the chosen segment's upper reading is not greater than its lower reading, the output is that segment's base code (0xBFF8, 0x8000, 0x8000 or 0x4007 from the top segment down), and `out_valid` rises in the cycle right after acceptance.
- R9: `in_ready` is low from the accepting edge until the result cycle has ended. `out_valid` is a one-cycle pulse. A request held during the result cycle is not taken there, and `in_ready` is 1 again in the following cycle.
- R10: A request that needs division (not bypass, not zero-width) raises `out_valid` 2·DATA_W+1 cycles after the cycle that follows the accepting edge. That is 33 cycles at the default width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block can take a request |
| in_bypass | input | 1 | Pass the raw code through uncorrected |
| in_raw | input | DATA_W | Raw converter code, offset binary |
| pt_neg_full | input | DATA_W | Calibration reading at the most negative level |
| pt_neg_half | input | DATA_W | Calibration reading at half the negative level |
| pt_zero | input | DATA_W | Calibration reading at zero input |
| pt_pos_half | input | DATA_W | Calibration reading at half the positive level |
| pt_pos_full | input | DATA_W | Calibration reading at the most positive level |
| out_valid | output | 1 | Result valid pulse |
| out_code | output | DATA_W | Corrected code |

## Verification
The overlap that matters here is the result cycle coinciding with a new request offer. The bench keeps `in_valid` high through the cycle in which `out_valid` is presented. It then checks in the next cycle that `in_ready` is back to 1 and no second result appeared, which would reveal a request taken during ST_DONE. Around this, several calibration sets are swept across the raw range, including points just either side of each calibration reading, zero-width segments and sets narrow enough to force clamping. Every result and its latency are compared against an integer model in the bench.

// File: rtl/calcor_pkg.sv
package calcor_pkg;

    typedef enum logic [1:0] {
        SEG_BELOW_NHALF = 2'd0,
        SEG_NEG_HALF    = 2'd1,
        SEG_POS_HALF    = 2'd2,
        SEG_ABOVE_PHALF = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_DONE   = 2'd2
    } state_e;

    localparam int unsigned CODE_W = 16;

    localparam logic [CODE_W-1:0] K_SCALE_UP   = 16'h3FF8;
    localparam logic [CODE_W-1:0] K_SCALE_DOWN = 16'h3FF9;
    localparam logic [CODE_W-1:0] K_BASE_TOP   = 16'hBFF8;
    localparam logic [CODE_W-1:0] K_BASE_MID   = 16'h8000;
    localparam logic [CODE_W-1:0] K_BASE_BOT   = 16'h4007;

endpackage

// File: rtl/calcor_segsel.sv
module calcor_segsel
    import calcor_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [DATA_W-1:0] p_nfull,
    input  logic [DATA_W-1:0] p_nhalf,
    input  logic [DATA_W-1:0] p_zero,
    input  logic [DATA_W-1:0] p_phalf,
    input  logic [DATA_W-1:0] p_pfull,
    output seg_e              seg,
    output logic [DATA_W-1:0] delta,
    output logic [DATA_W-1:0] span,
    output logic              flat,
    output logic [DATA_W-1:0] scale,
    output logic [DATA_W-1:0] base,
    output logic              upward
);

    logic [DATA_W-1:0] hi_pt;
    logic [DATA_W-1:0] lo_pt;

    always_comb begin
        if (raw >= p_phalf) begin
            seg    = SEG_ABOVE_PHALF;
            delta  = raw - p_phalf;
            hi_pt  = p_pfull;
            lo_pt  = p_phalf;
            scale  = K_SCALE_UP;
            base   = K_BASE_TOP;
            upward = 1'b1;
        end else if (raw >= p_zero) begin
            seg    = SEG_POS_HALF;
            delta  = raw - p_zero;
            hi_pt  = p_phalf;
            lo_pt  = p_zero;
            scale  = K_SCALE_UP;
            base   = K_BASE_MID;
            upward = 1'b1;
        end else if (raw >= p_nhalf) begin
            seg    = SEG_NEG_HALF;
            delta  = p_zero - raw;
            hi_pt  = p_zero;
            lo_pt  = p_nhalf;
            scale  = K_SCALE_DOWN;
            base   = K_BASE_MID;
            upward = 1'b0;
        end else begin
            seg    = SEG_BELOW_NHALF;
            delta  = p_nhalf - raw;
            hi_pt  = p_nhalf;
            lo_pt  = p_nfull;
            scale  = K_SCALE_DOWN;
            base   = K_BASE_BOT;
            upward = 1'b0;
        end
        flat = (hi_pt <= lo_pt);
        span = flat ? '0 : (hi_pt - lo_pt);
    end

endmodule

// File: rtl/calcor_divider.sv
module calcor_divider #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot
);

    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(NUM_W - 1);

    logic [DEN_W-1:0] rem_q;
    logic [NUM_W-1:0] quot_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;

    logic [DEN_W:0]   shifted;
    logic [DEN_W:0]   trial;
    logic             fits;

    always_comb begin
        shifted = {rem_q, quot_q[NUM_W-1]};
        trial   = shifted - {1'b0, den_q};
        fits    = (shifted >= {1'b0, den_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quot_q <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                quot_q <= num;
                den_q  <= den;
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q  <= fits ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
                quot_q <= {quot_q[NUM_W-2:0], fits};
                cnt_q  <= cnt_q + 1'b1;
                if (cnt_q == LAST_STEP) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        busy = busy_q;
        done = done_q;
        quot = quot_q;
    end

    AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (rem_q < den_q)); // R2

    AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q); // R9

endmodule

// File: rtl/cal_corrector.sv
module cal_corrector
    import calcor_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_bypass,
    input  logic [DATA_W-1:0] in_raw,
    input  logic [DATA_W-1:0] pt_neg_full,
    input  logic [DATA_W-1:0] pt_neg_half,
    input  logic [DATA_W-1:0] pt_zero,
    input  logic [DATA_W-1:0] pt_pos_half,
    input  logic [DATA_W-1:0] pt_pos_full,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_code
);

    localparam int PROD_W = 2 * DATA_W;
    localparam logic [PROD_W:0] CODE_MAX = (PROD_W+1)'({DATA_W{1'b1}});

    state_e state_q, state_d;

    seg_e              sel_seg;
    logic [DATA_W-1:0] sel_delta;
    logic [DATA_W-1:0] sel_span;
    logic              sel_flat;
    logic [DATA_W-1:0] sel_scale;
    logic [DATA_W-1:0] sel_base;
    logic              sel_up;

    logic [PROD_W-1:0] product;
    logic              accept;
    logic              div_start;
    logic              div_busy;
    logic              div_done;
    logic [PROD_W-1:0] div_quot;

    logic [DATA_W-1:0] base_q;
    logic              up_q;
    logic [DATA_W-1:0] code_q;
    logic [DATA_W-1:0] shaped;
    logic [PROD_W:0]   sum_wide;

    calcor_segsel #(.DATA_W(DATA_W)) u_segsel (
        .raw     (in_raw),
        .p_nfull (pt_neg_full),
        .p_nhalf (pt_neg_half),
        .p_zero  (pt_zero),
        .p_phalf (pt_pos_half),
        .p_pfull (pt_pos_full),
        .seg     (sel_seg),
        .delta   (sel_delta),
        .span    (sel_span),
        .flat    (sel_flat),
        .scale   (sel_scale),
        .base    (sel_base),
        .upward  (sel_up)
    );

    calcor_divider #(.NUM_W(PROD_W), .DEN_W(DATA_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (product),
        .den   (sel_span),
        .busy  (div_busy),
        .done  (div_done),
        .quot  (div_quot)
    );

    always_comb begin
        product   = PROD_W'(sel_delta) * PROD_W'(sel_scale);
        accept    = in_valid && (state_q == ST_IDLE);
        div_start = accept && !in_bypass && !sel_flat;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (in_bypass || sel_flat) ? ST_DONE : ST_DIVIDE;
                end
            end
            ST_DIVIDE: begin
                if (div_done) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result shaping with clamping at both ends of the code range
    always_comb begin
        sum_wide = {1'b0, PROD_W'(base_q)} + {1'b0, div_quot};
        if (up_q) begin
            shaped = (sum_wide > CODE_MAX) ? {DATA_W{1'b1}} : sum_wide[DATA_W-1:0];
        end else begin
            shaped = (div_quot > PROD_W'(base_q)) ? '0 : (base_q - div_quot[DATA_W-1:0]);
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            up_q   <= 1'b0;
            code_q <= '0;
        end else begin
            if (accept) begin
                base_q <= sel_base;
                up_q   <= sel_up;
                if (in_bypass) begin
                    code_q <= in_raw;
                end else if (sel_flat) begin
                    code_q <= sel_base;
                end
            end else if ((state_q == ST_DIVIDE) && div_done) begin
                code_q <= shaped;
            end
        end
    end

    // Outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_DONE);
        out_code  = code_q;
    end

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R9

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R9

    AST_BYPASS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_bypass) |=> (out_valid && out_code == $past(in_raw))); // R6

    AST_FLAT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_bypass && sel_flat) |=> (out_valid && out_code == $past(sel_base))); // R8

    AST_DIVIDE_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_bypass && !sel_flat) |=> (!out_valid && div_busy)); // R10

    AST_SEGMENT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !$isunknown(sel_seg)); // R2

endmodule

// File: tb/tb_cal_corrector.sv
module tb_cal_corrector;

    localparam int DW      = 16;
    localparam int DIV_LAT = 2 * DW + 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic          in_bypass;
    logic [DW-1:0] in_raw;
    logic [DW-1:0] pt_neg_full, pt_neg_half, pt_zero, pt_pos_half, pt_pos_full;
    logic          out_valid;
    logic [DW-1:0] out_code;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int cur [5];

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    cal_corrector #(.DATA_W(DW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_bypass   (in_bypass),
        .in_raw      (in_raw),
        .pt_neg_full (pt_neg_full),
        .pt_neg_half (pt_neg_half),
        .pt_zero     (pt_zero),
        .pt_pos_half (pt_pos_half),
        .pt_pos_full (pt_pos_full),
        .out_valid   (out_valid),
        .out_code    (out_code)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic int model(input int raw, input bit byp,
                                 output bit flat, output int seg, output bit clip);
        longint d, s, k, b, q, r;
        bit add;
        flat = 1'b0;
        clip = 1'b0;
        seg  = 0;
        if (byp) return raw;
        if (raw >= cur[3]) begin
            seg = 3; d = raw - cur[3]; s = cur[4] - cur[3]; k = 'h3FF8; b = 'hBFF8; add = 1;
        end else if (raw >= cur[2]) begin
            seg = 2; d = raw - cur[2]; s = cur[3] - cur[2]; k = 'h3FF8; b = 'h8000; add = 1;
        end else if (raw >= cur[1]) begin
            seg = 1; d = cur[2] - raw; s = cur[2] - cur[1]; k = 'h3FF9; b = 'h8000; add = 0;
        end else begin
            seg = 0; d = cur[1] - raw; s = cur[1] - cur[0]; k = 'h3FF9; b = 'h4007; add = 0;
        end
        flat = (s <= 0);
        q = flat ? 0 : (d * k) / s;
        r = add ? b + q : b - q;
        if (r > 65535) begin clip = 1; r = 65535; end
        if (r < 0)     begin clip = 1; r = 0; end
        return int'(r);
    endfunction

    task automatic run_one(input int raw, input bit byp);
        bit    flat, clip, ready_leak;
        int    seg, exp, lat_exp, n;
        string tag;
        exp = model(raw, byp, flat, seg, clip);
        if (byp)       tag = "R6";
        else if (flat) tag = "R8";
        else if (clip) tag = "R7";
        else if (seg == 3) tag = "R2";
        else if (seg == 2) tag = "R3";
        else if (seg == 1) tag = "R4";
        else tag = "R5";
        lat_exp = (byp || flat) ? 0 : DIV_LAT;

        @(negedge clk);
        check(in_ready === 1'b1, "R9", "ready before offer", int'(in_ready), 1);
        in_valid  = 1'b1;
        in_bypass = byp;
        in_raw    = DW'(raw);
        {pt_neg_full, pt_neg_half, pt_zero, pt_pos_half, pt_pos_full} =
            {DW'(cur[0]), DW'(cur[1]), DW'(cur[2]), DW'(cur[3]), DW'(cur[4])};
        @(posedge clk);
        n = 0;
        ready_leak = 1'b0;
        forever begin
            @(negedge clk);
            if (out_valid === 1'b1) break;
            if (in_ready !== 1'b0) ready_leak = 1'b1;
            n++;
            if (n > 200) begin
                check(1'b0, "R10", "watchdog on result", n, lat_exp);
                finish_run();
            end
        end
        check(!ready_leak, "R9", "ready low while busy", int'(ready_leak), 0);
        check(out_code === DW'(exp), tag, $sformatf("code raw=%0h", raw), int'(out_code), exp);
        check(n == lat_exp, (lat_exp == 0) ? (byp ? "R6" : "R8") : "R10", "latency", n, lat_exp);
        // keep the offer standing across the result cycle
        @(negedge clk);
        check(in_ready === 1'b1 && out_valid === 1'b0, "R9", "no take during result",
              int'({in_ready, out_valid}), 2);
        in_valid = 1'b0;
    endtask

    task automatic sweep_set(input int a, input int b, input int c, input int d, input int e);
        cur[0] = a; cur[1] = b; cur[2] = c; cur[3] = d; cur[4] = e;
        for (int raw = 0; raw <= 65535; raw += 233) run_one(raw, 1'b0);
        run_one(65535, 1'b0);
        for (int p = 0; p < 5; p++) begin
            for (int off = -1; off <= 1; off++) begin
                if (cur[p] + off >= 0 && cur[p] + off <= 65535) run_one(cur[p] + off, 1'b0);
            end
        end
    endtask

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_bypass = 1'b0;
        in_raw    = '0;
        {pt_neg_full, pt_neg_half, pt_zero, pt_pos_half, pt_pos_full} = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(in_ready === 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

        sweep_set('h0100, 'h4080, 'h8010, 'hBFA0, 'hFF00);
        sweep_set('h1000, 'h4800, 'h8200, 'hBC00, 'hF000);
        sweep_set('h6000, 'h7000, 'h8000, 'h9000, 'hA000);
        sweep_set('h5000, 'h5000, 'h8000, 'hA000, 'hA000);

        for (int raw = 0; raw <= 65535; raw += 4099) run_one(raw, 1'b1);
        run_one(65535, 1'b1);
        run_one(0, 1'b1);

        finish_run();
    end

    initial begin
        wait (cyc > 190000);
        check(1'b0, "R10", "global watchdog", cyc, 190000);
        finish_run();
    end

endmodule